// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block owns the instruction address register of a simple 32-bit processor and works out, every cycle, which address comes next. It looks at the instruction word fetched from the current address, together with a single flag that says whether the two source registers of that instruction hold the same value. From these it picks one of three next addresses. The first is the plain sequential address. The second is a conditional branch target relative to the already-advanced address. The third is a direct jump target built from a 26-bit word address and the upper bits of the current address.

For the jump-and-link operation the block also presents a write request for the register file. The request carries the return address and the fixed destination register index, in the same cycle as the instruction. A stall input freezes the address register and suppresses that write request. A synchronous active-low reset loads a parameterised start address.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc` takes the value of the `START_ADDR` parameter at that edge, whatever the other inputs are.
- R2: When the opcode (`instr[31:26]`) is none of 2, 3, 4 or 5 and `stall` is low, `pc` becomes `pc + 4` at the next edge.
- R3: Opcode 4 (branch on equal) with `regs_equal` high moves `pc` to `pc + 4 + (sign-extended instr[15:0] << 2)`. A negative offset wraps modulo 2^32.
- R4: Opcode 4 with `regs_equal` low moves `pc` to `pc + 4`.
- R5: Opcode 5 (branch on not equal) moves `pc` to the branch target of R3 when `regs_equal` is low, and to `pc + 4` when it is high.
- R6: Opcode 2 (jump) moves `pc` to `{pc[31:28], instr[25:0], 2'b00}`, using the upper bits of the current address and not those of `pc + 4`.
- R7: Opcode 3 (jump and link) moves `pc` to the R6 target. In the same cycle it drives `link_we` high, `link_data` = `pc + 4` and `link_addr` = 31.
- R8: While `stall` is high, `pc` keeps its value at the edge and `link_we` is low, for every opcode.
- R9: `link_we` is low for every opcode other than 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Hold the current address this cycle |
| instr | input | 32 | Instruction word fetched from `pc` |
| regs_equal | input | 1 | High when the two source registers are equal |
| pc | output | 32 | Current instruction address |
| link_we | output | 1 | Return-address write request |
| link_addr | output | 5 | Destination register index for the return address |
| link_data | output | 32 | Return address (`pc + 4`) |

## Verification
The hardest case to reach is a jump whose current address and sequential successor fall in different 256 MB regions. From the default start address no branch can reach such a boundary. The bench therefore builds a second instance whose start address sits two words below a region boundary. It steps that instance once and then issues a jump from the last word of the region. The main instance replays a short counting loop with a backward jump, and then a branch with the most negative offset, so that sign extension and wrap-around are covered.

// File: rtl/pc_next_pkg.sv
// Package: shared opcode values and the decoded control-flow kind.
// Assumes the opcode occupies the top six bits of the instruction word.
package pc_next_pkg;
    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_JMP = 6'd2;
    localparam logic [OPC_W-1:0] OPC_JAL = 6'd3;
    localparam logic [OPC_W-1:0] OPC_BEQ = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BNE = 6'd5;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BEQ,
        FLOW_BNE,
        FLOW_JMP,
        FLOW_JAL
    } flow_e;
endpackage

// File: rtl/pc_flow_decode.sv
// Decoder: classifies the opcode and resolves branch direction.
// Assumes regs_equal is valid in the same cycle as the instruction.
module pc_flow_decode
    import pc_next_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] instr,
    input  logic            regs_equal,
    output flow_e           kind,
    output logic            take_branch,
    output logic            take_jump
);
    localparam int OPC_LSB = XLEN - OPC_W;

    logic [OPC_W-1:0] opc;
    assign opc = instr[XLEN-1:OPC_LSB];

    // Map the opcode onto a control-flow kind.
    always_comb begin
        unique case (opc)
            OPC_BEQ: kind = FLOW_BEQ;
            OPC_BNE: kind = FLOW_BNE;
            OPC_JMP: kind = FLOW_JMP;
            OPC_JAL: kind = FLOW_JAL;
            default: kind = FLOW_SEQ;
        endcase
    end

    // Decide whether a branch or jump redirects the fetch.
    always_comb begin
        take_branch = ((kind == FLOW_BEQ) && regs_equal) ||
                      ((kind == FLOW_BNE) && !regs_equal);
        take_jump   = (kind == FLOW_JMP) || (kind == FLOW_JAL);
    end
endmodule

// File: rtl/pc_target_calc.sv
// Target calculator: forms sequential, PC-relative and region-direct
// addresses and selects one. Assumes word-aligned addresses.
module pc_target_calc #(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 16,
    parameter int JADDR_W = 26
) (
    input  logic [XLEN-1:0] pc_cur,
    input  logic [XLEN-1:0] instr,
    input  logic            take_branch,
    input  logic            take_jump,
    output logic [XLEN-1:0] pc_seq,
    output logic [XLEN-1:0] pc_next
);
    localparam int EXT_W = XLEN - IMM_W - 2;
    localparam int REG_W = XLEN - JADDR_W - 2;

    logic [IMM_W-1:0]   imm;
    logic [JADDR_W-1:0] jaddr;
    logic [XLEN-1:0]    br_off;
    logic [XLEN-1:0]    br_tgt;
    logic [XLEN-1:0]    jmp_tgt;

    assign imm   = instr[IMM_W-1:0];
    assign jaddr = instr[JADDR_W-1:0];

    // Compute the three candidate addresses.
    always_comb begin
        pc_seq  = pc_cur + XLEN'(4);
        br_off  = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        br_tgt  = pc_seq + br_off;
        jmp_tgt = {pc_cur[XLEN-1 -: REG_W], jaddr, 2'b00};
    end

    // Pick the redirect, jump before branch before sequential.
    always_comb begin
        if (take_jump)        pc_next = jmp_tgt;
        else if (take_branch) pc_next = br_tgt;
        else                  pc_next = pc_seq;
    end
endmodule

// File: rtl/pc_hold_reg.sv
// Address register: synchronous active-low reset to START_ADDR,
// holds while stall is high, otherwise loads the chosen address.
module pc_hold_reg #(
    parameter int              XLEN       = 32,
    parameter logic [XLEN-1:0] START_ADDR = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic [XLEN-1:0] pc_next,
    output logic [XLEN-1:0] pc_q
);
    // Update the current address once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= START_ADDR;
        else if (!stall) pc_q <= pc_next;
    end

    // R8: a stalled cycle leaves the address untouched.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc_q));
endmodule

// File: rtl/pc_next_unit.sv
// Top: program counter with next-address selection and link output.
// Assumes instr is the word fetched from pc in the same cycle.
module pc_next_unit
    import pc_next_pkg::*;
#(
    parameter int                  XLEN       = 32,
    parameter int                  IMM_W      = 16,
    parameter int                  JADDR_W    = 26,
    parameter int                  RIDX_W     = 5,
    parameter logic [RIDX_W-1:0]   LINK_REG   = 5'd31,
    parameter logic [XLEN-1:0]     START_ADDR = 32'h0001_3880
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic [XLEN-1:0]   instr,
    input  logic              regs_equal,
    output logic [XLEN-1:0]   pc,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_addr,
    output logic [XLEN-1:0]   link_data
);
    localparam int REG_W = XLEN - JADDR_W - 2;

    flow_e           kind;
    logic            take_branch;
    logic            take_jump;
    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] pc_next;

    pc_flow_decode #(.XLEN(XLEN)) u_dec (
        .instr       (instr),
        .regs_equal  (regs_equal),
        .kind        (kind),
        .take_branch (take_branch),
        .take_jump   (take_jump)
    );

    pc_target_calc #(.XLEN(XLEN), .IMM_W(IMM_W), .JADDR_W(JADDR_W)) u_tgt (
        .pc_cur      (pc),
        .instr       (instr),
        .take_branch (take_branch),
        .take_jump   (take_jump),
        .pc_seq      (pc_seq),
        .pc_next     (pc_next)
    );

    pc_hold_reg #(.XLEN(XLEN), .START_ADDR(START_ADDR)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .stall   (stall),
        .pc_next (pc_next),
        .pc_q    (pc)
    );

    // Drive the return-address write for jump-and-link.
    always_comb begin
        link_we   = (kind == FLOW_JAL) && !stall;
        link_addr = LINK_REG;
        link_data = pc_seq;
    end

    // R2: a non-control opcode advances by one word.
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && kind == FLOW_SEQ) |=> (pc == $past(pc) + XLEN'(4)));

    // R4: an equal-branch that fails falls through.
    p_beq_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && kind == FLOW_BEQ && !regs_equal) |=> (pc == $past(pc) + XLEN'(4)));

    // R6: a jump keeps the region bits of the current address.
    p_jump_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && take_jump) |=>
        (pc[XLEN-1 -: REG_W] == $past(pc[XLEN-1 -: REG_W]) && pc[1:0] == 2'b00));

    // R7: the link request returns one word past the current address.
    p_link_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |=> ($past(link_data) == $past(pc) + XLEN'(4)));
endmodule

// File: tb/tb_pc_next_unit.sv
// Scoreboard bench: the driver pushes the expected next address into a
// queue; the monitor pops and compares after each rising edge.
module tb_pc_next_unit;
    localparam logic [31:0] START    = 32'h0001_3880;
    localparam logic [31:0] START_HI = 32'hAFFF_FFF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic [31:0] instr = '0;
    logic        regs_equal = 1'b0;
    logic [31:0] pc;
    logic        link_we;
    logic [4:0]  link_addr;
    logic [31:0] link_data;

    logic        stall_hi = 1'b1;
    logic [31:0] instr_hi = '0;
    logic [31:0] pc_hi;
    logic        link_we_hi;
    logic [4:0]  link_addr_hi;
    logic [31:0] link_data_hi;

    int checks = 0;
    int failures = 0;
    logic [31:0] ref_pc;

    typedef struct {
        logic [31:0] pc;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    pc_next_unit #(.START_ADDR(START)) dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .instr(instr),
        .regs_equal(regs_equal), .pc(pc), .link_we(link_we),
        .link_addr(link_addr), .link_data(link_data)
    );

    pc_next_unit #(.START_ADDR(START_HI)) dut_hi (
        .clk(clk), .rst_n(rst_n), .stall(stall_hi), .instr(instr_hi),
        .regs_equal(1'b0), .pc(pc_hi), .link_we(link_we_hi),
        .link_addr(link_addr_hi), .link_data(link_data_hi)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_next(input logic [31:0] p, input logic [31:0] ins,
                                               input logic eq, output string tag);
        logic [5:0]  op;
        logic [31:0] seq;
        logic [31:0] br;
        op  = ins[31:26];
        seq = p + 32'd4;
        br  = seq + {{14{ins[15]}}, ins[15:0], 2'b00};
        if (op == 6'd4) begin
            tag = eq ? "R3" : "R4";
            return eq ? br : seq;
        end else if (op == 6'd5) begin
            tag = "R5";
            return eq ? seq : br;
        end else if (op == 6'd2 || op == 6'd3) begin
            tag = (op == 6'd2) ? "R6" : "R7";
            return {p[31:28], ins[25:0], 2'b00};
        end
        tag = "R2";
        return seq;
    endfunction

    // Driver: apply one instruction, check link outputs, queue next address.
    task automatic step(input logic [31:0] ins, input logic eq, input logic st);
        string       tag;
        logic [31:0] nxt;
        logic        jal;
        @(negedge clk);
        rst_n = 1'b1;
        instr = ins;
        regs_equal = eq;
        stall = st;
        #1;
        jal = (ins[31:26] == 6'd3);
        nxt = model_next(ref_pc, ins, eq, tag);
        if (st) begin
            check32("R8 link_we in stall", {31'd0, link_we}, 32'd0);
            nxt = ref_pc;
            tag = "R8";
        end else if (jal) begin
            check32("R7 link_we", {31'd0, link_we}, 32'd1);
            check32("R7 link_addr", {27'd0, link_addr}, 32'd31);
            check32("R7 link_data", link_data, ref_pc + 32'd4);
        end else begin
            check32("R9 link_we", {31'd0, link_we}, 32'd0);
        end
        exp_q.push_back('{pc: nxt, tag: tag});
        ref_pc = nxt;
    endtask

    task automatic do_reset(input logic [31:0] ins);
        @(negedge clk);
        rst_n = 1'b0;
        stall = 1'b1;
        instr = ins;
        exp_q.push_back('{pc: START, tag: "R1"});
        ref_pc = START;
    endtask

    // Monitor: compare the address just after each rising edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check32(e.tag, pc, e.pc);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    localparam logic [31:0] I_SLL  = {6'd0, 5'd0, 5'd19, 5'd9, 5'd2, 6'd0};
    localparam logic [31:0] I_ADD  = {6'd0, 5'd9, 5'd22, 5'd9, 5'd0, 6'd32};
    localparam logic [31:0] I_LW   = {6'd35, 5'd9, 5'd8, 16'd0};
    localparam logic [31:0] I_BNE  = {6'd5, 5'd8, 5'd21, 16'd2};
    localparam logic [31:0] I_ADDI = {6'd8, 5'd19, 5'd19, 16'd1};
    localparam logic [31:0] I_JMP  = {6'd2, 26'd20000};

    initial begin
        ref_pc = START;
        do_reset(32'h0c00_0000);
        // Counting loop at 80000: stays while equal, leaves on mismatch.
        for (int it = 0; it < 3; it++) begin
            step(I_SLL, 1'b0, 1'b0);
            step(I_ADD, 1'b1, 1'b0);
            step(I_LW, 1'b0, 1'b0);
            step(I_BNE, 1'b1, 1'b0);
            step(I_ADDI, 1'b0, 1'b0);
            step(I_JMP, 1'b0, 1'b0);
        end
        step(I_SLL, 1'b0, 1'b0);
        step(I_ADD, 1'b0, 1'b0);
        step(I_LW, 1'b0, 1'b0);
        step(I_BNE, 1'b0, 1'b0);
        check32("R5 loop exit", ref_pc, 32'd80024);
        // Equal-branch both ways, forward and most negative offset.
        step({6'd4, 10'd0, 16'h0010}, 1'b0, 1'b0);
        step({6'd4, 10'd0, 16'h0010}, 1'b1, 1'b0);
        step({6'd4, 10'd0, 16'h8000}, 1'b1, 1'b0);
        step({6'd5, 10'd0, 16'hFFFF}, 1'b0, 1'b0);
        // Stall against every redirect kind, including jal.
        step({6'd3, 26'h0000123}, 1'b0, 1'b1);
        step({6'd2, 26'h0000123}, 1'b0, 1'b1);
        step({6'd4, 10'd0, 16'h0040}, 1'b1, 1'b1);
        step({6'd3, 26'h0000123}, 1'b0, 1'b0);
        step(I_ADDI, 1'b1, 1'b0);
        // Reset in the middle of a jump overrides it.
        do_reset({6'd2, 26'h3FF_FFFF});
        step({6'd3, 26'd20000}, 1'b1, 1'b0);
        step(I_SLL, 1'b0, 1'b0);
        wait (exp_q.size() == 0);

        // Region boundary: second instance sits two words below it.
        @(negedge clk);
        stall_hi = 1'b0;
        instr_hi = I_SLL;
        @(posedge clk); #2;
        check32("R2 hi step", pc_hi, 32'hAFFF_FFFC);
        @(negedge clk);
        instr_hi = {6'd3, 26'h10};
        #1;
        check32("R7 hi link_data", link_data_hi, 32'hB000_0000);
        @(posedge clk); #2;
        check32("R6 hi region kept", pc_hi, 32'hA000_0040);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule